// File: doc/BRIEF.md
# Dual-Rate Bus Access Governor

This block sits between a fast processor bus and two memory regions. The fast region holds ROM, most RAM and expansion memory. The slow region holds the peripherals, the I/O page and 128 KB of RAM that peripheral DMA also reaches at the 1 MHz rate. The block is given one processor cycle at a time. It decodes the address and direction and then chooses how the cycle runs. It either completes the cycle at the fast rate or holds the processor until the next rising edge of the 1 MHz phase reference and runs the cycle with slow-bus timing.

The block also shadows display pages. Pages in the two low banks can be mirrored into the slow RAM. Reads of an enabled page are served by the fast copy at full speed. Writes to an enabled page update the fast copy at once and are then repeated on the slow bus. A speed register and a shadow register sit in the I/O page. The speed register's fast-enable bit can force every cycle to slow timing. The shadow register enables each mirrored window separately.

Top module: `dual_rate_bus_governor`

## Requirements
- R1: A cycle is accepted at a rising clock edge where `cpu_req` is high and the block is idle. A fast-region access (any bank other than 0x00, 0x01, 0xE0, 0xE1, or a low-bank address outside the I/O page and outside any enabled window) pulses `fast_sel` in the cycle after acceptance. It raises `cpu_done` FAST_LEN-1 cycles after that pulse and never pulses `slow_sel`.
- R2: An access to banks 0xE0/0xE1 outside the I/O page never pulses `fast_sel`. It pulses `slow_sel` in the cycle after the first edge after acceptance at which `slow_phase` is sampled 1, having been 0 at the edge before. At that pulse `slow_addr` equals address bits 16:0 and `slow_we` equals the direction. `cpu_done` follows SLOW_LEN-1 cycles after the `slow_sel` pulse.
- R3: The I/O page (address bits 15:12 = 0xC in banks 0x00, 0x01, 0xE0, 0xE1) always uses slow timing as in R2. It never pulses `fast_sel` and is never shadowed.
- R4: A read in bank 0x00/0x01 inside an enabled window runs with fast timing (R1) and does not pulse `slow_sel`.
- R5: A write in bank 0x00/0x01 inside an enabled window pulses `fast_sel` and `fast_we` in the cycle after acceptance. It then runs a slow cycle as in R2, with `slow_we` high.
- R6: While speed register bit 7 is 0, every access waits for the phase edge and ends SLOW_LEN-1 cycles after it. `fast_sel` and `slow_sel` still pulse only for the regions given in R1 to R5.
- R7: Shadow register bit i enables window i: bit 0 covers 0x0400-0x07FF, bit 1 covers 0x2000-0x3FFF, bit 2 covers 0x4000-0x5FFF and bit 3 covers 0x6000-0x9FFF. A write to a disabled window behaves as a fast-region access.
- R8: After reset, the speed register reads 0x80 and the shadow register reads 0x0F. `cpu_stall`, `cpu_done`, `fast_sel` and `slow_sel` are all low.
- R9: The speed register is at offset 0xC0F8 and the shadow register at offset 0xC0F9, in the I/O page. A write takes effect at the edge that ends the access. A read returns the value on `cpu_rdata` while `cpu_done` is high. Shadow bits 7:4 read 0. `cpu_rdata` is 0 at the end of every other access.
- R10: `cpu_req` is ignored while `cpu_stall` or `cpu_done` is high. `cpu_stall` is high from acceptance until the `cpu_done` cycle. `cpu_done` is a single-cycle pulse.
- R11: A phase rise sampled at the acceptance edge itself does not start the slow cycle. The block waits for the next rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor requests a bus cycle |
| cpu_addr | input | ADDR_W | Bank and offset of the access |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | 8 | Write data, used by the control registers |
| slow_phase | input | 1 | 1 MHz phase reference, synchronous to clk |
| cpu_stall | output | 1 | Holds the processor while a cycle runs |
| cpu_done | output | 1 | Cycle completes in this clock |
| cpu_rdata | output | 8 | Register read data, valid with cpu_done |
| fast_sel | output | 1 | One-cycle strobe for the fast-region memory |
| fast_we | output | 1 | Direction qualifying fast_sel |
| slow_sel | output | 1 | One-cycle strobe starting a slow-bus cycle |
| slow_we | output | 1 | Direction qualifying slow_sel |
| slow_addr | output | 17 | Offset inside the slow region, valid with slow_sel |

## Verification
For an access accepted at edge A, `fast_sel` is due in the cycle after A. On a fast cycle, `cpu_done` is due FAST_LEN-1 cycles later. On a slow cycle, `slow_sel` is due in the cycle after the first phase-rise edge R after A, and `cpu_done` is due SLOW_LEN-1 cycles after R. The driver works out A from the free-running edge count when it raises the request. It works out R from its own phase pattern and pushes these exact cycle numbers into the scoreboard. The monitor samples on falling edges. At every cycle it compares each strobe, `cpu_stall` and `cpu_done` against the cycle numbers of the oldest entry, so an early, late or extra strobe is reported in the cycle it happens.

// File: rtl/drg_pkg.sv
// Package: shared types and window table for the dual-rate bus governor.
// Assumes four mirrored windows, all in the low 64 KB of banks 0x00/0x01.
package drg_pkg;

    localparam int NUM_WIN = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FAST   = 2'd1,
        ST_WAITPH = 2'd2,
        ST_SLOW   = 2'd3
    } seq_state_t;

    // Per-access decision handed from the decoder to the sequencer
    typedef struct packed {
        logic fast_mem;   // fast-region memory takes part
        logic slow_bus;   // a slow-bus cycle must run
        logic stretch;    // cycle waits for the 1 MHz phase
        logic reg_speed;  // speed register selected
        logic reg_shadow; // shadow register selected
    } acc_class_t;

    // Lowest offset of mirrored window w
    function automatic logic [15:0] win_lo(input int w);
        case (w)
            0:       return 16'h0400;
            1:       return 16'h2000;
            2:       return 16'h4000;
            default: return 16'h6000;
        endcase
    endfunction

    // Highest offset of mirrored window w
    function automatic logic [15:0] win_hi(input int w);
        case (w)
            0:       return 16'h07FF;
            1:       return 16'h3FFF;
            2:       return 16'h5FFF;
            default: return 16'h9FFF;
        endcase
    endfunction

endpackage

// File: rtl/drg_decode.sv
// Module: drg_decode
// Classifies the presented address into region, shadow and register hits.
// Assumes a 64 KB offset in the low 16 address bits and the bank above them.
// The I/O page is excluded from shadowing so it always reaches the slow bus.
module drg_decode
    import drg_pkg::*;
#(
    parameter int                ADDR_W     = 24,
    parameter logic [ADDR_W-17:0] SLOW_BANK = 'hE0,
    parameter logic [15:0]       REG_SPEED  = 16'hC0F8,
    parameter logic [15:0]       REG_SHADOW = 16'hC0F9
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               we,
    input  logic               fast_on,
    input  logic [NUM_WIN-1:0] shadow_en,
    output acc_class_t         cls
);
    localparam int BANK_W = ADDR_W - 16;

    logic [BANK_W-1:0]  bank;
    logic [15:0]        ofs;
    logic               low_bank;
    logic               slow_bank;
    logic               io_page;
    logic               slow_ram;
    logic               shadowed;
    logic [NUM_WIN-1:0] win_hit;

    assign bank = addr[ADDR_W-1:16];
    assign ofs  = addr[15:0];

    // Window comparators, one per mirrored page range
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        assign win_hit[w] = (ofs >= win_lo(w)) && (ofs <= win_hi(w));
    end

    // Region, shadow and register classification
    always_comb begin
        low_bank       = (bank[BANK_W-1:1] == '0);
        slow_bank      = (bank[BANK_W-1:1] == SLOW_BANK[BANK_W-1:1]);
        io_page        = (low_bank || slow_bank) && (ofs[15:12] == 4'hC);
        slow_ram       = slow_bank && !io_page;
        shadowed       = low_bank && !io_page && |(win_hit & shadow_en);
        cls.fast_mem   = !io_page && !slow_ram;
        cls.slow_bus   = io_page || slow_ram || (shadowed && we);
        cls.stretch    = io_page || slow_ram || (shadowed && we) || !fast_on;
        cls.reg_speed  = io_page && (ofs == REG_SPEED);
        cls.reg_shadow = io_page && (ofs == REG_SHADOW);
    end

endmodule

// File: rtl/drg_ctrl_regs.sv
// Module: drg_ctrl_regs
// Holds the speed and shadow control registers and returns them on reads.
// Assumes commit is high for exactly the last cycle of each access.
module drg_ctrl_regs
    import drg_pkg::*;
#(
    parameter logic [7:0] SPEED_RST = 8'h80,
    parameter int         FAST_BIT  = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic               sel_speed,
    input  logic               sel_shadow,
    input  logic               we,
    input  logic [7:0]         wdata,
    output logic               fast_on,
    output logic [NUM_WIN-1:0] shadow_en,
    output logic [7:0]         rdata
);
    logic [7:0]         speed_q;
    logic [NUM_WIN-1:0] shadow_q;

    // Register update at the edge that ends a write access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            speed_q  <= SPEED_RST;
            shadow_q <= '1;
        end else if (commit && we) begin
            if (sel_speed)  speed_q  <= wdata;
            if (sel_shadow) shadow_q <= wdata[NUM_WIN-1:0];
        end
    end

    // Read mux, driven only during the completing cycle of a read
    always_comb begin
        rdata = '0;
        if (commit && !we) begin
            if (sel_speed)       rdata = speed_q;
            else if (sel_shadow) rdata = {{(8-NUM_WIN){1'b0}}, shadow_q};
        end
    end

    assign fast_on   = speed_q[FAST_BIT];
    assign shadow_en = shadow_q;

    // Registers leave reset holding their documented values
    assert_reset_vals_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (speed_q == SPEED_RST) && (&shadow_q));

    // Speed register changes only after a completing access
    assert_speed_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(speed_q) |-> $past(commit));

endmodule

// File: rtl/drg_seq.sv
// Module: drg_seq
// Runs one bus cycle at a time: fast cycles complete after FAST_LEN clocks,
// stretched cycles wait for the next 1 MHz phase rise and last SLOW_LEN.
// Assumes slow_phase is already synchronous to clk.
module drg_seq
    import drg_pkg::*;
#(
    parameter int FAST_LEN = 2,
    parameter int SLOW_LEN = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req,
    input  logic [16:0] req_ofs,
    input  logic        cpu_we,
    input  logic [7:0]  cpu_wdata,
    input  logic        slow_phase,
    input  acc_class_t  cls,
    output logic        cpu_stall,
    output logic        cpu_done,
    output logic        fast_sel,
    output logic        fast_we,
    output logic        slow_sel,
    output logic        slow_we,
    output logic [16:0] slow_addr,
    output logic        lat_speed,
    output logic        lat_shadow,
    output logic        lat_we,
    output logic [7:0]  lat_wdata
);
    localparam int LEN_MAX = (FAST_LEN > SLOW_LEN) ? FAST_LEN : SLOW_LEN;
    localparam int CNT_W   = $clog2(LEN_MAX + 1);

    seq_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ph_q;
    logic             ph_rise;
    logic             lat_slow_bus;
    logic [16:0]      lat_ofs;

    assign ph_rise   = slow_phase && !ph_q;
    assign cpu_done  = ((state_q == ST_FAST) || (state_q == ST_SLOW)) && (cnt_q == '0);
    assign cpu_stall = (state_q != ST_IDLE) && !cpu_done;

    // Cycle sequencer, phase edge tracking and strobe generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            cnt_q        <= '0;
            ph_q         <= 1'b1;
            fast_sel     <= 1'b0;
            fast_we      <= 1'b0;
            slow_sel     <= 1'b0;
            slow_we      <= 1'b0;
            slow_addr    <= '0;
            lat_slow_bus <= 1'b0;
            lat_ofs      <= '0;
            lat_speed    <= 1'b0;
            lat_shadow   <= 1'b0;
            lat_we       <= 1'b0;
            lat_wdata    <= '0;
        end else begin
            ph_q     <= slow_phase;
            fast_sel <= 1'b0;
            fast_we  <= 1'b0;
            slow_sel <= 1'b0;
            slow_we  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (cpu_req) begin
                        lat_slow_bus <= cls.slow_bus;
                        lat_ofs      <= req_ofs;
                        lat_speed    <= cls.reg_speed;
                        lat_shadow   <= cls.reg_shadow;
                        lat_we       <= cpu_we;
                        lat_wdata    <= cpu_wdata;
                        if (cls.fast_mem) begin
                            fast_sel <= 1'b1;
                            fast_we  <= cpu_we;
                        end
                        if (cls.stretch) begin
                            state_q <= ST_WAITPH;
                        end else begin
                            state_q <= ST_FAST;
                            cnt_q   <= CNT_W'(FAST_LEN - 1);
                        end
                    end
                end
                ST_WAITPH: begin
                    if (ph_rise) begin
                        state_q <= ST_SLOW;
                        cnt_q   <= CNT_W'(SLOW_LEN - 1);
                        if (lat_slow_bus) begin
                            slow_sel  <= 1'b1;
                            slow_we   <= lat_we;
                            slow_addr <= lat_ofs;
                        end
                    end
                end
                default: begin
                    if (cnt_q == '0) state_q <= ST_IDLE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
            endcase
        end
    end

    // A slow strobe follows an edge that saw the phase go from low to high
    assert_slow_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slow_sel |-> $past(slow_phase) && !$past(slow_phase, 2));

    // Completion is a single-cycle pulse
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // Fast memory strobe lasts one cycle
    assert_fast_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fast_sel |=> !fast_sel);

endmodule

// File: rtl/dual_rate_bus_governor.sv
// Module: dual_rate_bus_governor (top)
// Decodes each processor cycle, picks fast or stretched timing, mirrors
// enabled display windows and hosts the speed and shadow registers.
// Assumes one outstanding cycle at a time and a clk-synchronous phase input.
module dual_rate_bus_governor
    import drg_pkg::*;
#(
    parameter int                ADDR_W     = 24,
    parameter logic [ADDR_W-17:0] SLOW_BANK = 'hE0,
    parameter int                FAST_LEN   = 2,
    parameter int                SLOW_LEN   = 4,
    parameter logic [15:0]       REG_SPEED  = 16'hC0F8,
    parameter logic [15:0]       REG_SHADOW = 16'hC0F9,
    parameter logic [7:0]        SPEED_RST  = 8'h80,
    parameter int                FAST_BIT   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic [7:0]        cpu_wdata,
    input  logic              slow_phase,
    output logic              cpu_stall,
    output logic              cpu_done,
    output logic [7:0]        cpu_rdata,
    output logic              fast_sel,
    output logic              fast_we,
    output logic              slow_sel,
    output logic              slow_we,
    output logic [16:0]       slow_addr
);
    acc_class_t         cls;
    logic               fast_on;
    logic [NUM_WIN-1:0] shadow_en;
    logic               lat_speed;
    logic               lat_shadow;
    logic               lat_we;
    logic [7:0]         lat_wdata;

    drg_decode #(
        .ADDR_W    (ADDR_W),
        .SLOW_BANK (SLOW_BANK),
        .REG_SPEED (REG_SPEED),
        .REG_SHADOW(REG_SHADOW)
    ) u_decode (
        .addr     (cpu_addr),
        .we       (cpu_we),
        .fast_on  (fast_on),
        .shadow_en(shadow_en),
        .cls      (cls)
    );

    drg_seq #(
        .FAST_LEN(FAST_LEN),
        .SLOW_LEN(SLOW_LEN)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .req_ofs   (cpu_addr[16:0]),
        .cpu_we    (cpu_we),
        .cpu_wdata (cpu_wdata),
        .slow_phase(slow_phase),
        .cls       (cls),
        .cpu_stall (cpu_stall),
        .cpu_done  (cpu_done),
        .fast_sel  (fast_sel),
        .fast_we   (fast_we),
        .slow_sel  (slow_sel),
        .slow_we   (slow_we),
        .slow_addr (slow_addr),
        .lat_speed (lat_speed),
        .lat_shadow(lat_shadow),
        .lat_we    (lat_we),
        .lat_wdata (lat_wdata)
    );

    drg_ctrl_regs #(
        .SPEED_RST(SPEED_RST),
        .FAST_BIT (FAST_BIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (cpu_done),
        .sel_speed (lat_speed),
        .sel_shadow(lat_shadow),
        .we        (lat_we),
        .wdata     (lat_wdata),
        .fast_on   (fast_on),
        .shadow_en (shadow_en),
        .rdata     (cpu_rdata)
    );

endmodule

// File: tb/dual_rate_bus_governor_tb_top.sv
module dual_rate_bus_governor_tb_top;
    localparam int FAST_LEN = 2;
    localparam int SLOW_LEN = 4;
    localparam int PER      = 20;
    localparam logic [15:0] A_SPD = 16'hC0F8;
    localparam logic [15:0] A_SHD = 16'hC0F9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic        slow_phase = 1'b0;
    logic        cpu_stall, cpu_done, fast_sel, fast_we, slow_sel, slow_we;
    logic [7:0]  cpu_rdata;
    logic [16:0] slow_addr;

    int  cyc = 0;
    int  checks = 0;
    int  fails = 0;
    bit  mon_on = 1'b0;
    logic [7:0] m_speed = 8'h80;
    logic [3:0] m_shadow = 4'hF;

    typedef struct {
        int a; int fc; int sc; int dc;
        bit we; logic [16:0] sa; logic [7:0] rd; string tag;
    } exp_t;
    exp_t q[$];

    dual_rate_bus_governor #(.FAST_LEN(FAST_LEN), .SLOW_LEN(SLOW_LEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .slow_phase(slow_phase),
        .cpu_stall(cpu_stall), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .fast_sel(fast_sel), .fast_we(fast_we), .slow_sel(slow_sel),
        .slow_we(slow_we), .slow_addr(slow_addr)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    // Phase pattern: sampled high at edges e with e % PER >= PER/2
    always @(negedge clk) slow_phase = ((cyc + 1) % PER) >= (PER / 2);

    function automatic void chk(bit ok, string r, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", r, what, cyc, act, exp);
        end
    endfunction

    // Scoreboard monitor: compares every cycle against the oldest expectation
    always @(negedge clk) begin
        if (mon_on) begin
            if (q.size() != 0 && cyc >= q[0].a) begin
                exp_t it;
                it = q[0];
                chk(fast_sel == (cyc == it.fc), it.tag, "fast_sel", fast_sel, cyc == it.fc);
                chk(slow_sel == (cyc == it.sc), it.tag, "slow_sel", slow_sel, cyc == it.sc);
                chk(cpu_done == (cyc == it.dc), it.tag, "cpu_done", cpu_done, cyc == it.dc);
                chk(cpu_stall == (cyc < it.dc), it.tag, "cpu_stall R10", cpu_stall, cyc < it.dc);
                if (cyc == it.fc) chk(fast_we == it.we, it.tag, "fast_we", fast_we, it.we);
                if (cyc == it.sc) begin
                    chk(slow_we == it.we, it.tag, "slow_we", slow_we, it.we);
                    chk(slow_addr == it.sa, it.tag, "slow_addr", slow_addr, it.sa);
                end
                if (cyc >= it.dc) begin
                    chk(cpu_rdata == it.rd, it.tag, "cpu_rdata R9", cpu_rdata, it.rd);
                    void'(q.pop_front());
                end
            end else begin
                chk(!fast_sel && !slow_sel && !cpu_done && !cpu_stall, "R10", "idle outputs",
                    {fast_sel, slow_sel, cpu_done, cpu_stall}, 0);
            end
        end
    end

    // Driver: computes expected timing from the requirements, then issues the access
    task automatic do_acc(input logic [23:0] addr, input bit we, input logic [7:0] wd,
                          input string tag, input int align, input bit poke);
        bit low, slw, io, inwin, shad, fm, sb, st;
        int a, r;
        exp_t it;
        logic [15:0] o;
        @(negedge clk);
        while (cpu_stall || cpu_done) @(negedge clk);
        if (align >= 0) while (((cyc + 1) % PER) != align) @(negedge clk);
        o     = addr[15:0];
        low   = (addr[23:16] == 8'h00) || (addr[23:16] == 8'h01);
        slw   = (addr[23:16] == 8'hE0) || (addr[23:16] == 8'hE1);
        io    = (low || slw) && (o[15:12] == 4'hC);
        inwin = (m_shadow[0] && o >= 16'h0400 && o <= 16'h07FF) ||
                (m_shadow[1] && o >= 16'h2000 && o <= 16'h3FFF) ||
                (m_shadow[2] && o >= 16'h4000 && o <= 16'h5FFF) ||
                (m_shadow[3] && o >= 16'h6000 && o <= 16'h9FFF);
        shad  = low && !io && inwin;
        fm    = !io && !slw;
        sb    = io || slw || (shad && we);
        st    = sb || !m_speed[7];
        a     = cyc + 1;
        it.a  = a; it.we = we; it.sa = addr[16:0]; it.tag = tag;
        it.fc = fm ? a : -1;
        if (st) begin
            r = a + 1;
            while ((r % PER) != (PER / 2)) r++;
            it.sc = sb ? r : -1;
            it.dc = r + SLOW_LEN - 1;
        end else begin
            it.sc = -1;
            it.dc = a + FAST_LEN - 1;
        end
        it.rd = 8'h00;
        if (io && !we && o == A_SPD) it.rd = m_speed;
        if (io && !we && o == A_SHD) it.rd = {4'h0, m_shadow};
        if (io && we && o == A_SPD) m_speed = wd;
        if (io && we && o == A_SHD) m_shadow = wd[3:0];
        q.push_back(it);
        cpu_req = 1'b1; cpu_addr = addr; cpu_we = we; cpu_wdata = wd;
        @(negedge clk);
        if (poke) begin
            // Request held through the busy period must be ignored (R10)
            cpu_addr = 24'h00C0F8; cpu_we = 1'b1; cpu_wdata = 8'h00;
            while (cyc < it.dc) @(negedge clk);
        end
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic run_tests;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cpu_stall && !cpu_done && !fast_sel && !slow_sel, "R8", "reset outputs",
            {cpu_stall, cpu_done, fast_sel, slow_sel}, 0);
        mon_on = 1'b1;
        do_acc(24'h00C0F8, 0, 8'h00, "R8 speed reset", -1, 0);
        do_acc(24'h00C0F9, 0, 8'h00, "R8 shadow reset", -1, 0);
        do_acc(24'h021234, 0, 8'h00, "R1 fast read", -1, 0);
        do_acc(24'h05ABCD, 1, 8'h11, "R1 fast write", -1, 0);
        do_acc(24'hE00400, 0, 8'h00, "R2 slow ram read", -1, 0);
        do_acc(24'hE12000, 1, 8'h22, "R2 slow ram write", -1, 0);
        do_acc(24'h00C030, 0, 8'h00, "R3 io read", -1, 0);
        do_acc(24'hE0C000, 1, 8'h33, "R3 io write", -1, 0);
        do_acc(24'h000400, 0, 8'h00, "R4 shadow read w0", -1, 0);
        do_acc(24'h013000, 0, 8'h00, "R4 shadow read w1", -1, 0);
        do_acc(24'h000500, 1, 8'h44, "R5 shadow write w0", -1, 0);
        do_acc(24'h017000, 1, 8'h55, "R5 shadow write w3", -1, 0);
        do_acc(24'h004800, 1, 8'h56, "R5 shadow write w2", -1, 0);
        do_acc(24'h00C0F9, 1, 8'h0E, "R9 shadow reg write", -1, 0);
        do_acc(24'h000400, 1, 8'h66, "R7 disabled window write", -1, 0);
        do_acc(24'h002000, 1, 8'h77, "R7 enabled window write", -1, 0);
        do_acc(24'h00C0F9, 0, 8'h00, "R9 shadow reg readback", -1, 0);
        do_acc(24'h01C0F9, 1, 8'hF5, "R9 shadow upper bits", -1, 0);
        do_acc(24'h00C0F9, 0, 8'h00, "R9 shadow upper read", -1, 0);
        do_acc(24'h00C0F9, 1, 8'h00, "R7 all windows off", -1, 0);
        do_acc(24'h006000, 1, 8'h78, "R7 window3 off write", -1, 0);
        do_acc(24'h00C0F9, 1, 8'h0F, "R9 shadow restore", -1, 0);
        do_acc(24'hE00800, 0, 8'h00, "R10 poke slow", -1, 1);
        do_acc(24'h031000, 0, 8'h00, "R10 poke fast", -1, 1);
        do_acc(24'hE1C0F8, 1, 8'h00, "R6 speed off", -1, 0);
        do_acc(24'h021000, 0, 8'h00, "R6 fast region stretched", -1, 0);
        do_acc(24'h000400, 0, 8'h00, "R6 shadow read stretched", -1, 0);
        do_acc(24'h00C0F8, 0, 8'h00, "R6 speed readback", -1, 0);
        do_acc(24'h00C0F8, 1, 8'h80, "R6 speed restore", -1, 0);
        do_acc(24'h021000, 0, 8'h00, "R6 fast again", -1, 0);
        do_acc(24'hE00010, 0, 8'h00, "R11 rise at accept", PER / 2, 0);
        do_acc(24'hE00020, 1, 8'h99, "R11 rise after accept", PER / 2 - 1, 0);
        do_acc(24'h00C0F8, 1, 8'h7F, "R11 speed off aligned", PER / 2, 0);
        do_acc(24'h040000, 1, 8'h01, "R11 stretched aligned", PER / 2, 0);
        @(negedge clk);
        while (cpu_stall || cpu_done || q.size() != 0) @(negedge clk);
        repeat (30) @(negedge clk);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (150000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
            end
        join_any
        mon_on = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule